// File: doc/BRIEF.md
# Dual-Read Integer Register File with Mirrored Banks

This block is the integer register file of a RISC-style core. It has thirty-two registers of 32 bits each, addressed by a 5-bit register number. It serves two source-operand reads and one result write in every cycle.

The storage is built from two copies of a memory that has a single read port, as block RAM does. The first operand port reads only from bank A and the second operand port reads only from bank B. Each accepted write lands in both banks at the same address with the same data, so the two banks always hold identical contents.

Reads are synchronous: an address presented before a rising edge yields its data after that edge. Register 0 is hardwired to zero. A per-register valid bit makes every register read as zero after reset until it is first written. When a read address matches the write address in the same cycle, that port returns the value being written (write-first).

Top module: `regfile_dualbank`

## Requirements
- R1: A value written to register n (1 to 31) with write enable high is returned on either read port by any later read of n, until n is written again.
- R2: Reads are synchronous. The address on a read port at a rising edge determines that port's data output from just after that edge until the next edge.
- R3: Register 0 always reads as zero. A write addressed to register 0 has no effect on any read.
- R4: The two read ports are independent. In the same cycle, each returns the contents of its own address, for any pair of addresses.
- R5: Every write updates both banks. Reading the same address on both ports in one cycle gives equal data on both outputs.
- R6: When the write is enabled, targets a nonzero register, and the write address equals a port's read address at the same edge, that port outputs the new write data (write-first). Each port behaves this way on its own.
- R7: While reset (rst_n low) is asserted, both data outputs are zero. After reset, every register reads as zero until it is written. A reset in mid-operation clears all registers again.
- R8: With write enable low, the write address and write data change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | First operand register number |
| rd_data_a | output | 32 | First operand data, one cycle after the address |
| rd_addr_b | input | 5 | Second operand register number |
| rd_data_b | output | 32 | Second operand data, one cycle after the address |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Result data |

## Verification
Every read result is due exactly one rising edge after its address is applied. A write is visible at that same edge when the addresses collide, and from the next edge otherwise. The bench drives all inputs on the falling edge. It computes the expected data from its reference model in the state before the edge, updates the model with the write, and compares both outputs at the following falling edge. The reset check is the one exception: it is made while reset is held, with no edge needed.

// File: rtl/regfile_dualbank.sv
module regfile_dualbank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0]  live;

  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic [DATA_W-1:0] data_a_q, data_b_q;
  logic              live_a_q, live_b_q;

  wire wr_ok = wr_en && (wr_addr != '0);
  wire hit_a = wr_ok && (wr_addr == rd_addr_a);
  wire hit_b = wr_ok && (wr_addr == rd_addr_b);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      bank_a[wr_addr] <= wr_data;
      bank_b[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     live <= '0;
    else if (wr_ok) live[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a_q <= '0;
      data_a_q <= '0;
      live_a_q <= 1'b0;
    end else begin
      addr_a_q <= rd_addr_a;
      data_a_q <= hit_a ? wr_data : bank_a[rd_addr_a];
      live_a_q <= hit_a | live[rd_addr_a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_b_q <= '0;
      data_b_q <= '0;
      live_b_q <= 1'b0;
    end else begin
      addr_b_q <= rd_addr_b;
      data_b_q <= hit_b ? wr_data : bank_b[rd_addr_b];
      live_b_q <= hit_b | live[rd_addr_b];
    end
  end

  assign rd_data_a = (addr_a_q == '0 || !live_a_q) ? '0 : data_a_q;
  assign rd_data_b = (addr_b_q == '0 || !live_b_q) ? '0 : data_b_q;
endmodule

// File: rtl/regfile_dualbank_chk.sv
module regfile_dualbank_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DEPTH-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (wr_en && wr_addr != '0) seen[wr_addr] <= 1'b1;
  end

  assert_zero_reg_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |=> (rd_data_a == '0));
  assert_zero_reg_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |=> (rd_data_b == '0));

  assert_banks_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

  assert_bypass_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && wr_addr == rd_addr_a) |=> (rd_data_a == $past(wr_data)));
  assert_bypass_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && wr_addr == rd_addr_b) |=> (rd_data_b == $past(wr_data)));

  assert_unwritten_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen[rd_addr_a] && !(wr_en && wr_addr == rd_addr_a)) |=> (rd_data_a == '0));
  assert_unwritten_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen[rd_addr_b] && !(wr_en && wr_addr == rd_addr_b)) |=> (rd_data_b == '0));

  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr_a) && !wr_en) |=> $stable(rd_data_a));
endmodule

bind regfile_dualbank regfile_dualbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/regfile_dualbank_bench.sv
module regfile_dualbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  regfile_dualbank u_regfile_dualbank (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [31:0] expect_rd(input logic [4:0] ra, input logic we,
                                            input logic [4:0] wa, input logic [31:0] wd);
    if (ra == 5'd0) return 32'd0;
    if (we && wa == ra) return wd;
    return model[ra];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
  endtask

  task automatic step(input string tag, input logic [4:0] ra, input logic [4:0] rb,
                      input logic we, input logic [4:0] wa, input logic [31:0] wd);
    logic [31:0] ea, eb;
    rd_addr_a = ra; rd_addr_b = rb; wr_en = we; wr_addr = wa; wr_data = wd;
    ea = expect_rd(ra, we, wa, wd);
    eb = expect_rd(rb, we, wa, wd);
    if (we && wa != 5'd0) model[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    check({tag, " port A"}, rd_data_a, ea);
    check({tag, " port B"}, rd_data_b, eb);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    clear_model();
    @(negedge clk);
    @(negedge clk);
    check("R7 reset port A", rd_data_a, 32'd0);
    check("R7 reset port B", rd_data_b, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: all registers read zero before any write
    for (int i = 0; i < 32; i += 2) step("R7 fresh", 5'(i), 5'(i + 1), 1'b0, 5'd0, 32'd0);

    // R3: write to register 0 ignored
    step("R3 write x0", 5'd0, 5'd0, 1'b1, 5'd0, 32'hDEADBEEF);
    step("R3 read x0", 5'd0, 5'd0, 1'b0, 5'd0, 32'd0);

    // R1 and R5: write then read on both ports
    step("R1 write", 5'd3, 5'd4, 1'b1, 5'd7, 32'h1234_5678);
    step("R5 same addr", 5'd7, 5'd7, 1'b0, 5'd0, 32'd0);

    // R6: write-first on each port separately
    step("R6 bypass A", 5'd9, 5'd7, 1'b1, 5'd9, 32'hA5A5_0009);
    step("R6 bypass B", 5'd7, 5'd10, 1'b1, 5'd10, 32'h5A5A_000A);
    step("R6 bypass both", 5'd11, 5'd11, 1'b1, 5'd11, 32'hCAFE_F00D);

    // R8: disabled write changes nothing
    step("R8 disabled", 5'd1, 5'd2, 1'b0, 5'd7, 32'hFFFF_FFFF);
    step("R8 readback", 5'd7, 5'd31, 1'b0, 5'd0, 32'd0);

    // R2: held address, data holds across cycles
    step("R2 hold 1", 5'd31, 5'd7, 1'b1, 5'd31, 32'h8000_0001);
    step("R2 hold 2", 5'd31, 5'd7, 1'b0, 5'd0, 32'd0);

    // R4: random traffic on independent ports
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] ra, rb, wa;
      logic we;
      ra = 5'($urandom_range(0, 31));
      rb = (n % 7 == 0) ? ra : 5'($urandom_range(0, 31));
      we = ($urandom_range(0, 3) != 0);
      wa = (n % 5 == 0) ? rb : 5'($urandom_range(0, 31));
      step("R4 random", ra, rb, we, wa, $urandom());
    end

    // R5: sweep identical addresses on both ports to compare banks
    for (int i = 0; i < 32; i++) step("R5 sweep", 5'(i), 5'(i), 1'b0, 5'd0, 32'd0);

    // R7: mid-run reset clears everything
    rst_n = 1'b0;
    #1;
    check("R7 midreset port A", rd_data_a, 32'd0);
    check("R7 midreset port B", rd_data_b, 32'd0);
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) step("R7 after reset", 5'(i), 5'(31 - i), 1'b0, 5'd0, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule